// File: doc/BRIEF.md
# Ping-Pong Waveform Capture Buffer

This block captures a serial multichannel sample stream into one of two memory banks and hands the filled bank to a reader that runs on its own clock. Samples arrive one per strobe, and the channel index steps through 0 to NCH-1. A channel mask selects which channels are kept. Kept samples are also forwarded on a registered data/valid/gate output in the write clock domain.

The writer fills its bank at consecutive addresses. When the last location has been written, the banks swap if the reader has released its bank. If the reader still holds its bank, the writer flags a fault and keeps writing around the bank as a ring. It then swaps as soon as the release arrives. A stop pulse halts writing and requests an early swap. The reader releases its bank in one of two ways, fixed by a parameter: a read strobe at the last address, or any read strobe taken as a release pulse.

Bank ownership passes between the clock domains as toggle signals, each retimed through two flops.

Top module: `ping_pong_recorder`

## Requirements
- R1: While `rst` is high, and on the first clocks after it falls, `bufSync`, `bufHanded`, `waveValid`, `waveGate` and `rdReady` are 0 and `bufCount` is 0.
- R2: The channel index is 0 for the first `sampleStb` after reset and advances by one per strobe, wrapping after NCH-1. Bit i of `chanMask` selects channel i. One write clock after a strobe, `waveGate` is 1. At the same time `waveValid` equals the mask bit of that channel, and `waveData` carries the sample whenever `waveValid` is 1.
- R3: A sample is stored only if it is masked in, `writeEn` is 1 and writing is not halted. Stored samples go to consecutive locations of the write bank, starting at location 0 after reset or after a swap.
- R4: If the sample that fills location DEPTH-1 is stored while the reader holds no bank, `bufSync` is 1 for exactly one cycle, one write clock after that strobe. `bufHanded` is 1 on the next cycle, and `bufCount` rises by one in the same cycle as `bufSync`.
- R5: After a swap, `rdReady` rises within a few read clocks. `rdData` shows the word at `rdAddr` of the reader's bank one read clock after the address is applied.
- R6: With AUTO_FLIP=1, a `rdStb` at `rdAddr` = DEPTH-1 releases the bank and clears `rdReady`. A `rdStb` at any other address has no effect.
- R7: With AUTO_FLIP=0, any `rdStb` while `rdReady` is 1 releases the bank. A writer that was waiting then swaps on its own.
- R8: If the writer fills location DEPTH-1 while the reader holds the other bank, no swap occurs. Writing wraps to location 0, and the swap follows the release. The status then has bit AW (fault) set and bits AW-1:0 equal to the last location written.
- R9: A `stopPulse` halts storing and requests a swap. The swap happens on that clock if the reader holds no bank, and otherwise after the release. Samples that arrive while writing is halted are not stored. The status then reports the last location written, and writing resumes at location 0 of the other bank.
- R10: A bank that fills without overrun is reported with the fault bit at 0 and the location field at DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous reset, active high, held for several cycles of both clocks |
| sampleStb | input | 1 | One sample of the serial stream is present |
| sampleIn | input | DW | Sample value |
| chanMask | input | NCH | Channels to keep, bit 0 is channel 0 |
| writeEn | input | 1 | Level enable for storing samples |
| stopPulse | input | 1 | One-cycle request to halt writing and swap |
| waveValid | output | 1 | Forwarded sample is masked in |
| waveGate | output | 1 | A sample strobe occurred one clock earlier |
| waveData | output | DW | Forwarded sample value |
| bufSync | output | 1 | One-cycle pulse when the write bank ends |
| bufHanded | output | 1 | One-cycle pulse one clock after `bufSync` |
| bufCount | output | SW | Number of banks handed over |
| bufStatus | output | AW+1 | {fault, last location written} of the handed bank |
| rdClk | input | 1 | Read-side clock |
| rdStb | input | 1 | Read strobe / release pulse |
| rdAddr | input | AW | Read address |
| rdReady | output | 1 | Reader holds a filled bank |
| rdData | output | DW | Registered read data |

## Verification
A wrong bank pointer on either side shows up when a bank is read back. The data read would then be from the previous fill, or the locations beyond a stop would hold fresh values instead of stale ones. A wrong channel counter or write address shifts the stored pattern on the first readback. A broken handshake shows up as a missing or early `bufSync`. The swap is visible the cycle after the last write, and a release is visible within three write clocks of the read strobe. Fault and last-location errors show in `bufStatus` as soon as `bufHanded` pulses.

// File: rtl/ppr_pkg.sv
`timescale 1ns/1ps
package ppr_pkg;
  // strobes from control to datapath, all in the write clock domain
  typedef struct packed {
    logic wrEn;      // store sampleIn at the current write location
    logic fwdValid;  // forwarded sample is masked in
    logic fwdGate;   // a sample strobe was seen
  } wrCtl_t;
endpackage

// File: rtl/ppr_ctrl.sv
`timescale 1ns/1ps
module ppr_ctrl #(
  parameter int NCH       = 8,
  parameter int AW        = 10,
  parameter int SW        = 16,
  parameter bit AUTO_FLIP = 1'b1
) (
  input  logic              wrClk,
  input  logic              rst,
  input  logic              sampleStb,
  input  logic [NCH-1:0]    chanMask,
  input  logic              writeEn,
  input  logic              stopPulse,
  output ppr_pkg::wrCtl_t   wrCtl,
  output logic              wrBank,
  output logic [AW-1:0]     wrAddr,
  output logic              bufSync,
  output logic              bufHanded,
  output logic [SW-1:0]     bufCount,
  output logic [AW:0]       bufStatus,
  input  logic              rdClk,
  input  logic              rdStb,
  input  logic [AW-1:0]     rdAddr,
  output logic              rdBank,
  output logic              rdReady
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] LAST_ADDR = AW'((1 << AW) - 1);

  // ---------------- write clock domain ----------------
  logic [CW-1:0] chIdx;
  logic          halted, pending, fault, readerFree, wrTgl;
  logic [2:0]    relSync;
  logic          relTgl;

  logic inMask, doWrite, lastWrite, needFlip, flipNow, relEdge;

  assign inMask    = chanMask[chIdx];
  assign doWrite   = sampleStb & inMask & writeEn & ~halted & ~stopPulse;
  assign lastWrite = doWrite & (wrAddr == LAST_ADDR);
  assign needFlip  = pending | lastWrite | stopPulse;
  assign flipNow   = needFlip & readerFree;
  assign relEdge   = relSync[2] ^ relSync[1];

  assign wrCtl.wrEn     = doWrite;
  assign wrCtl.fwdValid = sampleStb & inMask;
  assign wrCtl.fwdGate  = sampleStb;

  always_ff @(posedge wrClk) begin
    if (rst) begin
      chIdx      <= '0;
      halted     <= 1'b0;
      pending    <= 1'b0;
      fault      <= 1'b0;
      readerFree <= 1'b1;
      wrTgl      <= 1'b0;
      wrBank     <= 1'b0;
      wrAddr     <= '0;
      relSync    <= '0;
      bufSync    <= 1'b0;
      bufHanded  <= 1'b0;
      bufCount   <= '0;
      bufStatus  <= '0;
    end else begin
      relSync   <= {relSync[1:0], relTgl};
      bufSync   <= flipNow;
      bufHanded <= bufSync;
      if (sampleStb)
        chIdx <= (chIdx == CW'(NCH - 1)) ? '0 : chIdx + CW'(1);
      if (relEdge)
        readerFree <= 1'b1;
      if (flipNow) begin
        wrBank     <= ~wrBank;
        wrAddr     <= '0;
        pending    <= 1'b0;
        halted     <= 1'b0;
        fault      <= 1'b0;
        readerFree <= 1'b0;
        wrTgl      <= ~wrTgl;
        bufCount   <= bufCount + SW'(1);
        bufStatus  <= {fault, doWrite ? wrAddr : wrAddr - AW'(1)};
      end else begin
        if (doWrite)   wrAddr  <= wrAddr + AW'(1);
        if (needFlip)  pending <= 1'b1;
        if (lastWrite) fault   <= 1'b1;
        if (stopPulse) halted  <= 1'b1;
      end
    end
  end

  // ---------------- read clock domain ----------------
  logic [2:0] wtSync;
  logic       atRelease, releaseNow;

  generate
    if (AUTO_FLIP) begin : g_autoRelease
      assign atRelease = (rdAddr == LAST_ADDR);
    end else begin : g_pulseRelease
      assign atRelease = 1'b1;
    end
  endgenerate

  assign releaseNow = rdReady & rdStb & atRelease;

  always_ff @(posedge rdClk) begin
    if (rst) begin
      wtSync  <= '0;
      rdBank  <= 1'b1;
      rdReady <= 1'b0;
      relTgl  <= 1'b0;
    end else begin
      wtSync <= {wtSync[1:0], wrTgl};
      if (wtSync[2] ^ wtSync[1]) begin
        rdBank  <= ~rdBank;
        rdReady <= 1'b1;
      end else if (releaseNow) begin
        rdReady <= 1'b0;
        relTgl  <= ~relTgl;
      end
    end
  end

  // ---------------- assertions ----------------
  p_handed_after_sync_r4: assert property (@(posedge wrClk) disable iff (rst)
    bufSync |=> bufHanded);
  p_sync_single_r4: assert property (@(posedge wrClk) disable iff (rst)
    bufSync |=> !bufSync);
  p_count_step_r4: assert property (@(posedge wrClk) disable iff (rst)
    bufSync |-> bufCount == $past(bufCount) + SW'(1));
  p_restart_addr_r9: assert property (@(posedge wrClk) disable iff (rst)
    bufSync |-> (wrAddr == '0) && !halted);
  p_halt_holds_addr_r9: assert property (@(posedge wrClk) disable iff (rst)
    ($past(halted) && halted) |-> $stable(wrAddr));
  p_overrun_no_swap_r8: assert property (@(posedge wrClk) disable iff (rst)
    (lastWrite && !readerFree) |=> !bufSync);
  p_release_toggles_r6: assert property (@(posedge rdClk) disable iff (rst)
    $fell(rdReady) |-> relTgl != $past(relTgl));
endmodule

// File: rtl/ppr_datapath.sv
`timescale 1ns/1ps
module ppr_datapath #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic            wrClk,
  input  logic            rst,
  input  ppr_pkg::wrCtl_t wrCtl,
  input  logic            wrBank,
  input  logic [AW-1:0]   wrAddr,
  input  logic [DW-1:0]   sampleIn,
  output logic            waveValid,
  output logic            waveGate,
  output logic [DW-1:0]   waveData,
  input  logic            rdClk,
  input  logic            rdBank,
  input  logic [AW-1:0]   rdAddr,
  output logic [DW-1:0]   rdData
);
  localparam int WORDS = 2 << AW;  // two banks

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wrClk) begin
    if (wrCtl.wrEn)
      mem[{wrBank, wrAddr}] <= sampleIn;
  end

  always_ff @(posedge wrClk) begin
    if (rst) begin
      waveValid <= 1'b0;
      waveGate  <= 1'b0;
      waveData  <= '0;
    end else begin
      waveValid <= wrCtl.fwdValid;
      waveGate  <= wrCtl.fwdGate;
      if (wrCtl.fwdGate) waveData <= sampleIn;
    end
  end

  always_ff @(posedge rdClk) begin
    rdData <= mem[{rdBank, rdAddr}];
  end

  p_valid_in_gate_r2: assert property (@(posedge wrClk) disable iff (rst)
    waveValid |-> waveGate);
endmodule

// File: rtl/ping_pong_recorder.sv
`timescale 1ns/1ps
module ping_pong_recorder #(
  parameter int NCH       = 8,
  parameter int DW        = 16,
  parameter int AW        = 10,
  parameter int SW        = 16,
  parameter bit AUTO_FLIP = 1'b1
) (
  input  logic           wrClk,
  input  logic           rst,
  input  logic           sampleStb,
  input  logic [DW-1:0]  sampleIn,
  input  logic [NCH-1:0] chanMask,
  input  logic           writeEn,
  input  logic           stopPulse,
  output logic           waveValid,
  output logic           waveGate,
  output logic [DW-1:0]  waveData,
  output logic           bufSync,
  output logic           bufHanded,
  output logic [SW-1:0]  bufCount,
  output logic [AW:0]    bufStatus,
  input  logic           rdClk,
  input  logic           rdStb,
  input  logic [AW-1:0]  rdAddr,
  output logic           rdReady,
  output logic [DW-1:0]  rdData
);
  ppr_pkg::wrCtl_t wrCtl;
  logic            wrBank, rdBank;
  logic [AW-1:0]   wrAddr;

  ppr_ctrl #(.NCH(NCH), .AW(AW), .SW(SW), .AUTO_FLIP(AUTO_FLIP)) u_ctrl (
    .wrClk(wrClk), .rst(rst), .sampleStb(sampleStb), .chanMask(chanMask),
    .writeEn(writeEn), .stopPulse(stopPulse), .wrCtl(wrCtl),
    .wrBank(wrBank), .wrAddr(wrAddr), .bufSync(bufSync),
    .bufHanded(bufHanded), .bufCount(bufCount), .bufStatus(bufStatus),
    .rdClk(rdClk), .rdStb(rdStb), .rdAddr(rdAddr), .rdBank(rdBank),
    .rdReady(rdReady)
  );

  ppr_datapath #(.DW(DW), .AW(AW)) u_data (
    .wrClk(wrClk), .rst(rst), .wrCtl(wrCtl), .wrBank(wrBank),
    .wrAddr(wrAddr), .sampleIn(sampleIn), .waveValid(waveValid),
    .waveGate(waveGate), .waveData(waveData), .rdClk(rdClk),
    .rdBank(rdBank), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/ping_pong_recorder_bench.sv
`timescale 1ns/1ps
module ping_pong_recorder_bench;
  localparam int NCH = 4, DW = 8, AW = 3, SW = 8, DEPTH = 8;

  logic wrClk = 0, rdClk = 0, rst = 1;
  logic sampleStb = 0, writeEn = 0, stopPulse = 0, rdStb = 0, rdStbX = 0;
  logic [DW-1:0] sampleIn = '0;
  logic [NCH-1:0] chanMask = '0;
  logic [AW-1:0] rdAddr = '0;

  logic waveValid, waveGate, bufSync, bufHanded, rdReady;
  logic [DW-1:0] waveData, rdData;
  logic [SW-1:0] bufCount;
  logic [AW:0] bufStatus;
  logic waveValidX, waveGateX, bufSyncX, bufHandedX, rdReadyX;
  logic [DW-1:0] waveDataX, rdDataX;
  logic [SW-1:0] bufCountX;
  logic [AW:0] bufStatusX;

  always #4 wrClk = ~wrClk;     // 125 MHz
  always #5.5 rdClk = ~rdClk;

  ping_pong_recorder #(.NCH(NCH), .DW(DW), .AW(AW), .SW(SW), .AUTO_FLIP(1'b1)) u_ping_pong_recorder (
    .wrClk(wrClk), .rst(rst), .sampleStb(sampleStb), .sampleIn(sampleIn),
    .chanMask(chanMask), .writeEn(writeEn), .stopPulse(stopPulse),
    .waveValid(waveValid), .waveGate(waveGate), .waveData(waveData),
    .bufSync(bufSync), .bufHanded(bufHanded), .bufCount(bufCount),
    .bufStatus(bufStatus), .rdClk(rdClk), .rdStb(rdStb), .rdAddr(rdAddr),
    .rdReady(rdReady), .rdData(rdData));

  ping_pong_recorder #(.NCH(NCH), .DW(DW), .AW(AW), .SW(SW), .AUTO_FLIP(1'b0)) u_ping_pong_recorder_x (
    .wrClk(wrClk), .rst(rst), .sampleStb(sampleStb), .sampleIn(sampleIn),
    .chanMask(chanMask), .writeEn(writeEn), .stopPulse(stopPulse),
    .waveValid(waveValidX), .waveGate(waveGateX), .waveData(waveDataX),
    .bufSync(bufSyncX), .bufHanded(bufHandedX), .bufCount(bufCountX),
    .bufStatus(bufStatusX), .rdClk(rdClk), .rdStb(rdStbX), .rdAddr(rdAddr),
    .rdReady(rdReadyX), .rdData(rdDataX));

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the main instance
  int expMem [16];
  int ch = 0, mWrAddr = 0, mBank = 0, nFlips = 0, lastStat = 0, val = 16;
  bit mFree = 1, mFault = 0, mHalt = 0, flipSeen = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic flipModel(input int lastLoc);
    lastStat = (int'(mFault) << AW) | lastLoc;
    mBank ^= 1; mWrAddr = 0; mFree = 0; mFault = 0; mHalt = 0;
    nFlips++;
  endtask

  task automatic afterFlip();
    @(negedge wrClk);
    chk(bufHanded == 1'b1, "R4 handed pulse", bufHanded, 1);
    chk(bufSync == 1'b0, "R4 sync one cycle", bufSync, 0);
    chk(int'(bufCount) == nFlips, "R4 bank count", bufCount, nFlips);
    chk(int'(bufStatus) == lastStat, "R8/R9/R10 status", bufStatus, lastStat);
  endtask

  task automatic sendSample();
    bit masked, wrote, expFlip;
    int v;
    v = val & 8'hff; val++;
    @(negedge wrClk);
    sampleStb = 1; sampleIn = DW'(v);
    masked  = chanMask[ch];
    wrote   = masked && writeEn && !mHalt;
    expFlip = wrote && mWrAddr == DEPTH-1 && mFree;
    @(negedge wrClk);
    sampleStb = 0;
    chk(waveGate == 1'b1, "R2 gate", waveGate, 1);
    chk(waveValid == masked, "R2 valid follows mask", waveValid, masked);
    if (masked) chk(int'(waveData) == v, "R2 forwarded data", waveData, v);
    chk(bufSync == expFlip, "R4 sync timing", bufSync, expFlip);
    if (wrote) expMem[mBank*DEPTH + mWrAddr] = v;
    ch = (ch + 1) % NCH;
    flipSeen = expFlip;
    if (expFlip) begin
      flipModel(DEPTH-1);
      afterFlip();
    end else if (wrote) begin
      if (mWrAddr == DEPTH-1) mFault = 1;
      mWrAddr = (mWrAddr + 1) % DEPTH;
    end
  endtask

  task automatic waitFlip();
    bit seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge wrClk);
      seen = bufSync;
    end
    chk(seen, "R8/R9 swap after release", seen, 1);
    flipModel((mWrAddr + DEPTH - 1) % DEPTH);
    afterFlip();
  endtask

  task automatic waitReady();
    bit seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge rdClk);
      seen = rdReady;
    end
    chk(seen, "R5 reader ready", seen, 1);
  endtask

  task automatic readBank(input int b);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge rdClk); rdAddr = AW'(a);
      @(negedge rdClk);
      chk(int'(rdData) == expMem[b*DEPTH + a], "R3/R5 readback", rdData, expMem[b*DEPTH + a]);
    end
  endtask

  task automatic strobeRd(input int a);
    @(negedge rdClk); rdAddr = AW'(a); rdStb = 1;
    @(negedge rdClk); rdStb = 0;
  endtask

  task automatic doStop(input bit immediate);
    @(negedge wrClk); stopPulse = 1;
    @(negedge wrClk); stopPulse = 0;
    chk(bufSync == immediate, "R9 stop swap timing", bufSync, immediate);
    if (immediate) begin
      flipModel((mWrAddr + DEPTH - 1) % DEPTH);
      afterFlip();
    end else mHalt = 1;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) expMem[i] = 0;
    repeat (6) @(negedge rdClk);
    @(negedge wrClk); rst = 0;
    // R1 reset state
    @(negedge wrClk);
    chk(!bufSync && !bufHanded, "R1 pulses idle", bufSync, 0);
    chk(bufCount == 0, "R1 count zero", bufCount, 0);
    chk(!waveValid && !waveGate, "R1 forward idle", waveValid, 0);
    chk(!rdReady && !rdReadyX, "R1 reader idle", rdReady, 0);

    // Phase B: fill bank 0, mask channels 0,1,3 (R2, R3, R4, R10)
    chanMask = 4'b1011; writeEn = 1;
    flipSeen = 0;
    for (int i = 0; i < 20 && !flipSeen; i++) sendSample();
    chk(nFlips == 1, "R4 first swap", nFlips, 1);
    waitReady();
    chk(rdReadyX == 1'b1, "R5 second reader ready", rdReadyX, 1);
    readBank(0);
    strobeRd(3);
    @(negedge rdClk);
    chk(rdReady == 1'b1, "R6 strobe off last address ignored", rdReady, 1);
    // explicit-release instance: any strobe releases (R7)
    @(negedge rdClk); rdAddr = 3'd2; rdStbX = 1;
    @(negedge rdClk); rdStbX = 0;
    chk(rdReadyX == 1'b0, "R7 pulse releases", rdReadyX, 0);
    chk(rdReady == 1'b1, "R6 other instance unaffected", rdReady, 1);

    // Phase C: overrun while reader holds bank 0 (R8)
    for (int i = 0; i < 30 && !(mBank == 1 && mFault && mWrAddr == 2); i++) sendSample();
    chk(int'(bufCountX) == 2, "R7 waiting writer swapped", bufCountX, 2);
    strobeRd(DEPTH-1);
    chk(rdReady == 1'b0, "R6 last-address strobe releases", rdReady, 1'b0);
    waitFlip();
    waitReady();
    readBank(1);

    // Phase D: writeEn low, then stop while reader busy (R3, R9)
    chanMask = 4'b1111; writeEn = 0;
    sendSample();
    writeEn = 1;
    repeat (3) sendSample();
    doStop(1'b0);
    repeat (2) sendSample();
    strobeRd(DEPTH-1);
    waitFlip();
    waitReady();
    readBank(0);

    // stop with free reader: immediate swap, writing resumed at location 0
    sendSample();
    strobeRd(DEPTH-1);
    repeat (10) @(negedge wrClk);
    doStop(1'b1);
    waitReady();
    readBank(1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule